// File: doc/BRIEF.md
# Daisy-Chained Serial Configuration Loader

This block keeps a device's setup bits in a serial shift chain that must be filled before the device does any normal work. A serial clock moves one bit per edge into the chain, but only while the active-low chain enable input is held low. Once the last setup bit has arrived, the block drives its active-low done output low. It then stops capturing bits and routes its serial input straight to its serial output, so the bits that follow reach the next device.

Several loaders cascade. The done output of one loader drives the chain enable of the next, and the serial output of one feeds the serial input of the next. A controller streams the whole configuration into the first device and waits for the done output of the last device to go low. A ready output tells the rest of the chip when normal operation is allowed.

Top module: `cfg_chain_loader`

## Requirements
- R1: While `rst_ni` is low and just after it is released, `done_no` is 1, `ready_o` is 0, `cfg_o` is all zeros and `sdata_o` is 0.
- R2: A rising `clk_i` edge with `chain_en_ni` high changes neither `cfg_o` nor the count of loaded bits.
- R3: Each rising `clk_i` edge with `chain_en_ni` low, before the chain is full, shifts `sdata_i` into `cfg_o[0]` and moves every bit up one position. After N such edges, the first bit received sits in `cfg_o[N-1]` and the last in `cfg_o[0]`.
- R4: `done_no` stays 1 until N bits have been loaded. It goes low as soon as N bits are loaded and `chain_en_ni` is low.
- R5: Once loaded, `done_no` equals `chain_en_ni` in the same cycle, combinationally, in both directions.
- R6: Once loaded with `done_no` low, `sdata_o` equals `sdata_i` combinationally. Further clock edges do not alter `cfg_o`.
- R7: Before the chain is full, `sdata_o` shows `cfg_o[N-1]`, the bit at the far end of the register.
- R8: `ready_o` is 1 exactly when `done_no` is 0.
- R9: When two loaders are cascaded (done output to enable input, serial output to serial input), the second loader captures the N bits that follow the first loader's N bits. Its `done_no` goes low after 2N enabled edges.
- R10: Once loaded with `chain_en_ni` high, `sdata_o` shows `cfg_o[N-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| sdata_i | input | 1 | Serial data in |
| chain_en_ni | input | 1 | Active-low chain enable from the previous stage |
| sdata_o | output | 1 | Serial data out to the next stage |
| done_no | output | 1 | Active-low loaded indication; drives the next stage's enable |
| ready_o | output | 1 | High when the device may begin normal operation |
| cfg_o | output | N | Parallel view of the loaded setup bits |

## Verification
The bench cascades two 4-bit loaders and streams every 8-bit pattern through them, computing each expected register image by shifting the pattern arithmetically.

It targets three kinds of error:
- **Off-by-one count.** A counter that finishes one bit early or late misplaces the split between the two devices, so both `cfg_o` images come out wrong.
- **Enable gating.** Each load is paused mid-way with enable high while the data toggles. A design that ignores the enable while shifting stores garbage.
- **Post-load behaviour.** Extra bits are pushed after the chain is full and the enable is raised and lowered. A design that keeps shifting, latches `done_no` instead of letting it track the enable, or selects the wrong output source fails there.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

  typedef enum logic {
    SEL_TAIL   = 1'b0,
    SEL_BYPASS = 1'b1
  } out_sel_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/cfg_bit_counter.sv
module cfg_bit_counter #(
  parameter int unsigned N = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_en_i,
  output logic loaded_o
);
  localparam int unsigned CW = cfg_chain_pkg::cnt_width(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);
  localparam logic [CW-1:0] FULL = CW'(N);

  logic [CW-1:0] cnt_q;
  logic          loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      loaded_q <= 1'b0;
    end else if (shift_en_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) loaded_q <= 1'b1;
    end
  end

  assign loaded_o = loaded_q;

  a_r4_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  a_r4_flag_matches_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q == (cnt_q == FULL));
  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |=> loaded_q);
  a_r2_hold_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(cnt_q));

endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         sdata_i,
  output logic [N-1:0] data_o,
  output logic         tail_o
);
  logic [N-1:0] q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic d;
    if (i == 0) begin : g_head
      assign d = sdata_i;
    end else begin : g_link
      assign d = q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q[i] <= 1'b0;
      else if (shift_en_i) q[i] <= d;
    end
  end

  assign data_o = q;
  assign tail_o = q[N-1];

  a_r2_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(data_o));
  a_r3_head_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> data_o[0] == $past(sdata_i));

endmodule

// File: rtl/cfg_pass_mux.sv
module cfg_pass_mux (
  input  cfg_chain_pkg::out_sel_e sel_i,
  input  logic                    tail_i,
  input  logic                    sdata_i,
  output logic                    sdata_o
);
  always_comb begin
    unique case (sel_i)
      cfg_chain_pkg::SEL_BYPASS: sdata_o = sdata_i;
      default:                   sdata_o = tail_i;
    endcase
  end
endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sdata_i,
  input  logic         chain_en_ni,
  output logic         sdata_o,
  output logic         done_no,
  output logic         ready_o,
  output logic [N-1:0] cfg_o
);
  import cfg_chain_pkg::*;

  logic     loaded;
  logic     shift_en;
  logic     tail;
  out_sel_e sel;

  // capture only while enabled and not yet full
  assign shift_en = !chain_en_ni && !loaded;

  cfg_bit_counter #(.N(N)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .loaded_o   (loaded)
  );

  cfg_shift_reg #(.N(N)) u_sreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .sdata_i    (sdata_i),
    .data_o     (cfg_o),
    .tail_o     (tail)
  );

  assign done_no = loaded ? chain_en_ni : 1'b1;
  assign ready_o = loaded && !chain_en_ni;
  assign sel     = (loaded && !chain_en_ni) ? SEL_BYPASS : SEL_TAIL;

  cfg_pass_mux u_mux (
    .sel_i   (sel),
    .tail_i  (tail),
    .sdata_i (sdata_i),
    .sdata_o (sdata_o)
  );

  a_r5_enable_high_done_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_en_ni |-> done_no);
  a_r6_bypass_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_no |-> sdata_o == sdata_i);
  a_r6_cfg_frozen_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_no |=> $stable(cfg_o));
  a_r8_ready_vs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o == !done_no);
  a_r7_tail_before_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_no && !loaded) |-> sdata_o == cfg_o[N-1]);

endmodule

// File: tb/cfg_chain_loader_tb_top.sv
module cfg_chain_loader_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sd_in = 1'b0;
  logic en_n = 1'b1;
  logic sd1, done1, rdy1, sd2, done2, rdy2;
  logic [N-1:0] cfg1, cfg2;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  cfg_chain_loader #(.N(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sd_in), .chain_en_ni(en_n),
    .sdata_o(sd1), .done_no(done1), .ready_o(rdy1), .cfg_o(cfg1)
  );

  cfg_chain_loader #(.N(N)) dut2_i (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sd1), .chain_en_ni(done1),
    .sdata_o(sd2), .done_no(done2), .ready_o(rdy2), .cfg_o(cfg2)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d time=%0t", req, got, exp, $time);
    end
  endtask

  function automatic int img(input int p, input int k);
    return (p >> (2 * N - k)) & ((1 << N) - 1);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < (1 << (2 * N)); p++) begin
      rst_n = 1'b0; en_n = 1'b1; sd_in = 1'b0;
      @(negedge clk); #1;
      chk("R1 done", int'(done1), 1);
      chk("R1 ready", int'(rdy1), 0);
      chk("R1 cfg", int'(cfg1), 0);
      chk("R1 sdata_o", int'(sd1), 0);
      rst_n = 1'b1;
      for (int k = 0; k < 2 * N; k++) begin
        if (k == 2) begin
          // R2: pause mid-load with toggling data
          for (int j = 0; j < 3; j++) begin
            @(negedge clk); en_n = 1'b1; sd_in = ~sd_in; #1;
            chk("R2 cfg frozen", int'(cfg1), img(p, 2));
            chk("R4 done high mid-load", int'(done1), 1);
          end
        end
        @(negedge clk); en_n = 1'b0; sd_in = p[2*N-1-k]; #1;
        if (k < N) begin
          chk("R3 partial image", int'(cfg1), img(p, k));
          chk("R7 tail out", int'(sd1), (img(p, k) >> (N - 1)) & 1);
          chk("R4 done high", int'(done1), 1);
          chk("R8 ready low", int'(rdy1), 0);
        end else begin
          chk("R6 bypass", int'(sd1), int'(sd_in));
          chk("R4 done low", int'(done1), 0);
          chk("R8 ready high", int'(rdy1), 1);
          chk("R9 second busy", int'(done2), 1);
        end
      end
      @(negedge clk); sd_in = ~sd_in; #1;
      chk("R3 first image", int'(cfg1), (p >> N) & ((1 << N) - 1));
      chk("R9 second image", int'(cfg2), p & ((1 << N) - 1));
      chk("R9 second done", int'(done2), 0);
      chk("R8 second ready", int'(rdy2), 1);
      chk("R6 chain bypass", int'(sd2), int'(sd_in));
      @(negedge clk); #1;
      chk("R6 extra bit no effect 1", int'(cfg1), (p >> N) & ((1 << N) - 1));
      chk("R6 extra bit no effect 2", int'(cfg2), p & ((1 << N) - 1));
      en_n = 1'b1; #1;
      chk("R5 done follows enable high", int'(done1), 1);
      chk("R5 cascade done high", int'(done2), 1);
      chk("R8 ready drops", int'(rdy1), 0);
      chk("R10 tail when enable high", int'(sd1), (p >> (2 * N - 1)) & 1);
      @(negedge clk); sd_in = ~sd_in; #1;
      chk("R2 loaded cfg held", int'(cfg1), (p >> N) & ((1 << N) - 1));
      en_n = 1'b0; #1;
      chk("R5 done follows enable low", int'(done1), 0);
      chk("R5 cascade done low", int'(done2), 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule